// File: doc/BRIEF.md
# Iterative Euclid GCD Engine

This block finds the greatest common divisor of two unsigned integers. It repeatedly swaps and subtracts the pair, and each clock cycle performs exactly one step. A small controller drives the datapath registers through explicit multiplexer selects and write enables. The datapath returns two status flags to the controller: one says the first operand is less than the second, and one says the second operand is zero.

A producer offers an operand pair with a valid/ready handshake. While the engine is busy it accepts nothing. When the second operand reaches zero, the first operand is the answer. The engine then presents that answer on a valid/ready output and holds it until a consumer takes it. After the take, the engine goes back to accepting operands.

Top module: `gcd_iter_unit`

## Requirements
- R1: Out of reset, and after any reset asserted in the middle of a computation, `op_ready` is 1 and `res_valid` is 0.
- R2: `op_ready` is 1 only while idle. A pair is captured on a clock edge where `op_valid` and `op_ready` are both 1. Operands offered while busy have no effect on the result.
- R3: In a compute cycle where the first operand is less than the second, the two operand registers exchange values.
- R4: In a compute cycle where the first operand is not less than the second and the second is nonzero, the first becomes their difference and the second is unchanged.
- R5: The computation ends when the second operand is zero. `res_out` then equals the greatest common divisor. A pair of zeros yields 0, and a single zero operand yields the other operand.
- R6: Exactly one step happens per cycle. The number of clock edges from the accepting edge to `res_valid` going high is the number of swap and subtract steps plus one. For example, (32, 48) takes 6 steps and gives 16 after 7 edges.
- R7: While `res_valid` is 1 and `res_ready` is 0, `res_valid` stays 1 and `res_out` does not change.
- R8: On an edge where `res_valid` and `res_ready` are both 1, the engine goes idle: the next cycle has `op_ready` = 1 and `res_valid` = 0.
- R9: `op_ready` and `res_valid` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_a_in | input | W | First operand |
| op_b_in | input | W | Second operand |
| op_valid | input | 1 | Producer offers an operand pair |
| op_ready | output | 1 | Engine is idle and will capture a pair |
| res_out | output | W | Greatest common divisor, meaningful while `res_valid` is 1 |
| res_valid | output | 1 | Result is available |
| res_ready | input | 1 | Consumer takes the result |

## Verification
A wrong step decision, such as a swap taken when a subtract was due, shows up at the ports in two ways. The result arrives too early or too late relative to the step count the reference model predicts. The final value may also be wrong. Both show up on the first pair that exercises the faulty branch. A stuck or misdirected controller state shows within one cycle as `op_ready` or `res_valid` out of place. This includes ready during computation, a result dropped without a take, and no return to idle. A result register that drifts while the engine waits on the consumer is caught in the stall cycles the bench inserts before each take.

// File: rtl/gcd_pkg.sv
// Shared encodings for the GCD engine: controller states and mux selects.
// Assumes nothing beyond 2-bit select fields.
package gcd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } gcd_state_t;

    typedef enum logic [1:0] {
        ASEL_LOAD = 2'd0,
        ASEL_SWAP = 2'd1,
        ASEL_DIFF = 2'd2
    } a_sel_t;

    typedef enum logic {
        BSEL_LOAD = 1'b0,
        BSEL_SWAP = 1'b1
    } b_sel_t;

endpackage

// File: rtl/gcd_datapath.sv
// Operand registers, the less-than compare, the zero detect and the subtractor.
// Assumes the controller drives the selects and enables each cycle; holds otherwise.
module gcd_datapath
    import gcd_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] load_a,
    input  logic [W-1:0] load_b,
    input  a_sel_t       a_sel,
    input  logic         a_en,
    input  b_sel_t       b_sel,
    input  logic         b_en,
    output logic         a_lt_b,
    output logic         b_zero,
    output logic [W-1:0] a_val
);

    logic [W-1:0] a_q, b_q, a_d, b_d, diff;

    // Status flags and difference from the present operands
    always_comb begin
        a_lt_b = a_q < b_q;
        b_zero = (b_q == '0);
        diff   = a_q - b_q;
    end

    // Next-value muxes for both operand registers
    always_comb begin
        unique case (a_sel)
            ASEL_SWAP: a_d = b_q;
            ASEL_DIFF: a_d = diff;
            default:   a_d = load_a;
        endcase
        b_d = (b_sel == BSEL_SWAP) ? a_q : load_b;
    end

    // Operand registers with enables
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
        end else begin
            if (a_en) a_q <= a_d;
            if (b_en) b_q <= b_d;
        end
    end

    assign a_val = a_q;

    AST_SWAP_ONLY_WHEN_LT: assert property (@(posedge clk) disable iff (!rst_n)
        (a_en && a_sel == ASEL_SWAP) |-> (a_lt_b && b_en && b_sel == BSEL_SWAP)); // R3

    AST_SUB_ONLY_WHEN_GE: assert property (@(posedge clk) disable iff (!rst_n)
        (a_en && a_sel == ASEL_DIFF) |-> (!a_lt_b && !b_zero && !b_en)); // R4

    AST_SUB_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (a_en && a_sel == ASEL_DIFF) |=> (a_q < $past(a_q))); // R4

endmodule

// File: rtl/gcd_control.sv
// Three-state controller: idle (take operands), run (one step per cycle),
// hold (present result until taken). Assumes status flags reflect current registers.
module gcd_control
    import gcd_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   op_valid,
    input  logic   res_ready,
    input  logic   a_lt_b,
    input  logic   b_zero,
    output a_sel_t a_sel,
    output logic   a_en,
    output b_sel_t b_sel,
    output logic   b_en,
    output logic   op_ready,
    output logic   res_valid
);

    gcd_state_t state_q, state_d;

    // Select, enable, handshake and next-state decode
    always_comb begin
        a_sel     = ASEL_LOAD;
        b_sel     = BSEL_LOAD;
        a_en      = 1'b0;
        b_en      = 1'b0;
        op_ready  = 1'b0;
        res_valid = 1'b0;
        state_d   = state_q;
        unique case (state_q)
            ST_IDLE: begin
                op_ready = 1'b1;
                if (op_valid) begin
                    a_en    = 1'b1;
                    b_en    = 1'b1;
                    state_d = ST_RUN;
                end
            end
            ST_RUN: begin
                if (a_lt_b) begin
                    a_sel = ASEL_SWAP;
                    b_sel = BSEL_SWAP;
                    a_en  = 1'b1;
                    b_en  = 1'b1;
                end else if (!b_zero) begin
                    a_sel = ASEL_DIFF;
                    a_en  = 1'b1;
                end else begin
                    state_d = ST_HOLD;
                end
            end
            ST_HOLD: begin
                res_valid = 1'b1;
                if (res_ready) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous reset to idle
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    AST_READY_VALID_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_ready && res_valid)); // R9

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |=> res_valid); // R7

    AST_TAKE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_ready) |=> (op_ready && !res_valid)); // R8

    AST_ACCEPT_LEAVES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_ready) |=> !op_ready); // R2

endmodule

// File: rtl/gcd_iter_unit.sv
// Top of the iterative GCD engine: wires controller to datapath.
// Assumes a single clock and synchronous active-low reset; one request in flight.
module gcd_iter_unit
    import gcd_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] op_a_in,
    input  logic [W-1:0] op_b_in,
    input  logic         op_valid,
    output logic         op_ready,
    output logic [W-1:0] res_out,
    output logic         res_valid,
    input  logic         res_ready
);

    a_sel_t a_sel;
    b_sel_t b_sel;
    logic   a_en, b_en, a_lt_b, b_zero;

    gcd_control i_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_valid  (op_valid),
        .res_ready (res_ready),
        .a_lt_b    (a_lt_b),
        .b_zero    (b_zero),
        .a_sel     (a_sel),
        .a_en      (a_en),
        .b_sel     (b_sel),
        .b_en      (b_en),
        .op_ready  (op_ready),
        .res_valid (res_valid)
    );

    gcd_datapath #(.W(W)) i_dp (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_a (op_a_in),
        .load_b (op_b_in),
        .a_sel  (a_sel),
        .a_en   (a_en),
        .b_sel  (b_sel),
        .b_en   (b_en),
        .a_lt_b (a_lt_b),
        .b_zero (b_zero),
        .a_val  (res_out)
    );

    AST_RESULT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |=> $stable(res_out)); // R7

    AST_DONE_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> b_zero); // R5

endmodule

// File: tb/test_gcd_iter_unit.sv
// Self-checking bench: table of operand pairs, then directed reset/ignore tests.
module test_gcd_iter_unit;

    localparam int W  = 16;
    localparam int NV = 10;
    localparam logic [W-1:0] VA [NV] = '{16'd32, 16'd48, 16'd0, 16'd0, 16'd9,
                                        16'd1, 16'd65535, 16'd17, 16'd1000, 16'd12};
    localparam logic [W-1:0] VB [NV] = '{16'd48, 16'd32, 16'd0, 16'd7, 16'd0,
                                        16'd65535, 16'd65535, 16'd13, 16'd250, 16'd18};
    localparam logic [W-1:0] VG [NV] = '{16'd16, 16'd16, 16'd0, 16'd7, 16'd9,
                                        16'd1, 16'd65535, 16'd1, 16'd250, 16'd6};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] op_a_in = '0, op_b_in = '0;
    logic         op_valid = 1'b0, res_ready = 1'b0;
    logic         op_ready, res_valid;
    logic [W-1:0] res_out;
    int           n_checks = 0, n_fail = 0;

    always #10 clk = ~clk;

    gcd_iter_unit #(.W(W)) i_gcd_iter_unit (
        .clk(clk), .rst_n(rst_n), .op_a_in(op_a_in), .op_b_in(op_b_in),
        .op_valid(op_valid), .op_ready(op_ready), .res_out(res_out),
        .res_valid(res_valid), .res_ready(res_ready)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference: subtract/swap steps and final value
    function automatic void ref_gcd(input logic [W-1:0] a0, input logic [W-1:0] b0,
                                    output logic [W-1:0] g, output int steps);
        logic [W-1:0] a = a0, b = b0, t;
        steps = 0;
        while (a < b || b != 0) begin
            if (a < b) begin t = a; a = b; b = t; end
            else a = a - b;
            steps++;
        end
        g = a;
    endfunction

    // One full transaction; optionally keeps offering junk operands while busy
    task automatic run_pair(input logic [W-1:0] a, input logic [W-1:0] b,
                            input logic [W-1:0] exp_g, input bit junk);
        logic [W-1:0] mg;
        int steps, edges;
        ref_gcd(a, b, mg, steps);
        check(mg == exp_g, "R5", mg, exp_g);
        check(op_ready == 1'b1, "R2", op_ready, 1);
        op_a_in = a; op_b_in = b; op_valid = 1'b1;
        @(posedge clk); @(negedge clk);
        if (junk) begin op_a_in = 16'd5; op_b_in = 16'd5; end
        else op_valid = 1'b0;
        check(op_ready == 1'b0, "R2", op_ready, 0);
        edges = 0;
        while (!res_valid && edges < 70000) begin
            @(posedge clk); @(negedge clk);
            edges++;
            if (!res_valid) check(op_ready == 1'b0, "R2", op_ready, 0);
        end
        op_valid = 1'b0;
        check(edges == steps + 1, "R6", edges, steps + 1);
        check(res_out == exp_g, "R5", res_out, exp_g);
        repeat (2) begin
            @(posedge clk); @(negedge clk);
            check(res_valid == 1'b1 && res_out == exp_g, "R7", res_out, exp_g);
            check(op_ready == 1'b0, "R9", op_ready, 0);
        end
        res_ready = 1'b1;
        @(posedge clk); @(negedge clk);
        res_ready = 1'b0;
        check(op_ready == 1'b1 && res_valid == 1'b0, "R8", {op_ready, res_valid}, 2);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        check(op_ready == 1'b1 && res_valid == 1'b0, "R1", {op_ready, res_valid}, 2);
        // Table: covers swap (R3), subtract (R4), zero operands (R5)
        for (int i = 0; i < NV; i++) run_pair(VA[i], VB[i], VG[i], 1'b0);
        // Operands offered while busy are ignored (R2)
        run_pair(16'd12, 16'd18, 16'd6, 1'b1);
        // Reset in the middle of a long computation returns to idle (R1)
        op_a_in = 16'd1; op_b_in = 16'd65535; op_valid = 1'b1;
        @(posedge clk); @(negedge clk); op_valid = 1'b0;
        repeat (5) @(posedge clk);
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); @(negedge clk); rst_n = 1'b1;
        check(op_ready == 1'b1 && res_valid == 1'b0, "R1", {op_ready, res_valid}, 2);
        run_pair(16'd21, 16'd14, 16'd7, 1'b0);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule